// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block models the control path of a single-cycle synchronous burst SRAM with a small storage array inside. On each rising clock edge it samples a three-input chip select, two address strobes (one meant for a processor, one for a cache or memory controller), a burst advance input, and the write enables. When a cycle is started, it captures the address and loads a two-bit burst counter from the lowest address bits. Later cycles step that counter to move through four consecutive words.

Writes are decoded per byte lane. A global write stores every lane. A byte write stores only the lanes whose strobes are active. Read data is registered, so it appears on the clock after the address is captured or advanced. The data bus drive enable is a separate output. It combines the registered read-valid state with an asynchronous active-low output enable. It also hides the first read that follows a deselect. A bidirectional pad around the block would use `rdata` and `rdata_oe` to drive the data pins.

Top module: `sburst_sram`

## Requirements
- R1: After reset, `rdata_oe` is 0, and the block counts as deselected.
- R2: The block is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on the edge. If a cycle is started by a strobe while the block is not selected, nothing is written, the burst is ended, and `rdata_oe` is 0 on the following cycle.
- R3: If `adsp_n` and `adsc_n` are both 0, only the processor strobe acts, and its cycle is always a read. Any write enables are ignored. When `ce1_n`=1, `adsp_n` is ignored completely, so an ongoing burst continues as if no strobe were present.
- R4: A started read captures `addr`. One cycle later `rdata` holds the word at that address and `rdata_oe` is 1.
- R5: With `adv_n`=0 and no strobe, bits [1:0] of the effective address step by +1 modulo 4 (linear order, 3 wraps to 0). The upper address bits stay as captured.
- R6: With `adv_n`=1 and no strobe during a burst, the effective address is held, and a read returns the same word again.
- R7: With `gw_n`=0, all byte lanes are written, whatever `bwe_n` and `bw_n` are.
- R8: With `gw_n`=1 and `bwe_n`=0, lane i (bits 8i+7:8i) is written only when `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1, the cycle is a read and no lane is written.
- R9: A cycle started by `adsc_n` may write at `addr`. A continuation write goes to the address produced by that same edge, so after an advance it goes to the next word.
- R10: `rdata_oe` follows `oe_n` without a clock: it is 0 whenever `oe_n`=1.
- R11: The first read started after a deselect (or after reset) keeps `rdata_oe` at 0 for its output cycle. The read that follows it drives normally.
- R12: A write cycle leaves `rdata_oe` at 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all control inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low, higher priority |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | NB | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data, sampled with the write enables |
| rdata | output | DW | Registered read data |
| rdata_oe | output | 1 | Data bus drive enable |

## Verification
Every result except the output-enable gate is registered once. A strobe, an advance or a write set on one edge shows its effect in `rdata` and `rdata_oe` after that edge. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares on the next falling edge. The `oe_n` gate is combinational, so it is checked a short delay after `oe_n` changes, with no clock edge in between. Results of byte and global writes are seen through a later read burst. These reads are compared with a lane-merge model kept in the bench.

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  localparam int LW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-3:0] hi;
  logic [1:0]    bc;
  logic          active, rvalid, desel, mask;
  logic [NB-1:0] lanes;

  wire sel    = !ce1_n && ce2 && !ce3_n;
  wire pstb   = !adsp_n && !ce1_n;
  wire strobe = pstb || !adsc_n;
  wire cont   = !strobe && active;
  wire go     = (strobe && sel) || cont;

  wire [1:0]    nxt = strobe ? addr[1:0] : (adv_n ? bc : bc + 2'd1);
  wire [AW-1:0] eff = strobe ? addr : {hi, nxt};

  always_comb lanes = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);

  wire wr = go && !pstb && (|lanes);
  wire rd = go && !wr;

  always_ff @(posedge clk) begin
    if (wr)
      for (int i = 0; i < NB; i++)
        if (lanes[i]) mem[eff][i*LW +: LW] <= wdata[i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi     <= '0;
      bc     <= '0;
      active <= 1'b0;
      rvalid <= 1'b0;
      desel  <= 1'b1;
      mask   <= 1'b0;
      rdata  <= '0;
    end else begin
      mask <= 1'b0;
      if (strobe && !sel) begin
        active <= 1'b0;
        rvalid <= 1'b0;
        desel  <= 1'b1;
      end else if (go) begin
        if (strobe) begin
          hi     <= addr[AW-1:2];
          active <= 1'b1;
          desel  <= 1'b0;
        end
        bc     <= nxt;
        rvalid <= rd;
        mask   <= rd && strobe && desel;
        if (rd) rdata <= mem[eff];
      end
    end
  end

  assign rdata_oe = rvalid && !oe_n && !mask;

  a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !sel) |=> !rdata_oe);

  a_r3_adsp_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !adsc_n && !ce1_n && sel) |=> rvalid);

  a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !adv_n) |=> bc == $past(bc) + 2'd1);

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> $stable(hi));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && adv_n) |=> $stable(bc));

  a_r11_first_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (desel && strobe && sel && rd) |=> !rdata_oe);

  a_r12_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !rdata_oe);
endmodule

// File: tb/sburst_sram_test.sv
module sburst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, DW = 32, NB = 4;

  logic clk = 0, rst_n = 0;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic rdata_oe;
  logic [DW-1:0] model [1<<AW];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sburst_sram #(.AW(AW), .DW(DW), .NB(NB)) uut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe));

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0; addr = '0; wdata = '0;
  endtask

  task automatic mwrite(int a, logic [NB-1:0] ln, logic [DW-1:0] d);
    for (int i = 0; i < NB; i++)
      if (ln[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic t_reset();
    chk("R1 oe after reset", rdata_oe, 0);
  endtask

  task automatic t_fill();
    idle(); adsc_n = 0; addr = 8; gw_n = 0; wdata = 32'h1111_0008;
    tick(); mwrite(8, '1, wdata);
    chk("R12 oe after write", rdata_oe, 0);
    adsc_n = 1; adv_n = 0;
    for (int k = 1; k < 4; k++) begin
      wdata = 32'h2222_0000 + k; tick(); mwrite(8 + k, '1, wdata);
      chk("R9 oe during burst write", rdata_oe, 0);
    end
    idle();
  endtask

  task automatic t_read_burst();
    idle(); adsp_n = 0; addr = 9; tick();
    chk("R4 read data", rdata, model[9]); chk("R4 read oe", rdata_oe, 1);
    adsp_n = 1; adv_n = 0;
    tick(); chk("R9 burst word 10", rdata, model[10]);
    tick(); chk("R5 burst word 11", rdata, model[11]);
    tick(); chk("R5 wrap to 8", rdata, model[8]);
    adv_n = 1; tick(); chk("R6 hold word 8", rdata, model[8]);
    chk("R6 oe on hold", rdata_oe, 1);
  endtask

  task automatic t_oe();
    oe_n = 1; #1; chk("R10 oe_n high", rdata_oe, 0);
    oe_n = 0; #1; chk("R10 oe_n low", rdata_oe, 1);
  endtask

  task automatic t_byte();
    idle(); adsc_n = 0; addr = 9; bwe_n = 0; bw_n = 4'b1010;
    wdata = 32'hAABB_CCDD; tick(); mwrite(9, 4'b0101, wdata);
    addr = 10; bwe_n = 1; bw_n = 4'b0000; wdata = 32'hDEAD_BEEF; tick();
    chk("R8 no write oe", rdata_oe, 1); chk("R8 no write data", rdata, model[10]);
    adsc_n = 1; adsp_n = 0; addr = 9; tick();
    chk("R8 byte lanes", rdata, model[9]);
    idle();
  endtask

  task automatic t_gw_override();
    idle(); adsc_n = 0; addr = 11; gw_n = 0; bwe_n = 0; bw_n = '1;
    wdata = 32'h5A5A_A5A5; tick(); mwrite(11, '1, wdata);
    idle(); adsp_n = 0; addr = 11; tick();
    chk("R7 global write", rdata, model[11]);
    idle();
  endtask

  task automatic t_prio();
    idle(); adsp_n = 0; adsc_n = 0; addr = 8; gw_n = 0; wdata = 32'hBAD0_BAD0;
    tick(); chk("R3 both strobes read oe", rdata_oe, 1);
    chk("R3 both strobes data", rdata, model[8]);
    idle(); ce1_n = 1; adsp_n = 0; adv_n = 0; addr = 40; tick();
    chk("R3 adsp ignored ce1 high", rdata, model[9]);
    chk("R3 adsp ignored oe", rdata_oe, 1);
    idle(); adsp_n = 0; addr = 8; tick();
    chk("R3 no write by adsp cycle", rdata, model[8]);
    idle();
  endtask

  task automatic t_desel();
    idle(); ce2 = 0; adsc_n = 0; addr = 10; gw_n = 0; wdata = 32'hFFFF_0000;
    tick(); chk("R2 deselect oe", rdata_oe, 0);
    idle(); adsp_n = 0; addr = 8; tick();
    chk("R11 first read masked", rdata_oe, 0);
    chk("R11 first read data", rdata, model[8]);
    adsp_n = 1; adv_n = 0; tick();
    chk("R11 second read oe", rdata_oe, 1);
    chk("R11 second read data", rdata, model[9]);
    idle(); ce3_n = 1; adsc_n = 0; addr = 10; gw_n = 0; wdata = 32'h0BAD_F00D;
    tick(); chk("R2 ce3 deselect oe", rdata_oe, 0);
    idle(); adsp_n = 0; addr = 10; tick();
    chk("R11 masked after ce3 deselect", rdata_oe, 0);
    chk("R2 no write while deselected", rdata, model[10]);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_read_burst();
    t_oe();
    t_byte();
    t_gw_override();
    t_prio();
    t_desel();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule